// File: doc/BRIEF.md
# Miss Fill Buffer with Flush Cancel

This block tracks the data cache misses that are waiting for a line from the next memory level. Each tracking entry holds the line address of the missing cache line. It also holds the micro-op tags of the loads that wait for that line. Two load ports can present a miss in the same cycle. Each port gets an accept or a reject answer in that same cycle, together with the entry index it was given. A second miss to a line that is already pending joins the existing entry and does not take a new one.

When the line comes back, the memory side names the entry index. The block then sends the returned beat to the pipeline once for each waiting tag, one tag per cycle, in the order the tags joined. A pipeline flush does not release any entries. It marks every occupied entry as cancelled, so that its data is never sent to the pipeline. An entry becomes free only when its own fill arrives. As a result, requests issued after a flush can still be refused while the cancelled traffic drains. Refused requests are counted.

Top module: `miss_fill_buffer`

## Requirements
- R1: After reset all entries are free: `buf_full`=0, `fwd_valid`=0, `full_events`=0 and `fill_ready`=1.
- R2: A miss to a line with no pending, non-cancelled entry is accepted in the same cycle if an entry is free. Port 0 takes the lowest free index. Port 1 takes the next lowest free index. `req_slot` reports the index.
- R3: A miss that needs a new entry when none is free is rejected in the same cycle. `full_events` grows by one for each rejected port in that cycle. `buf_full` is 1 whenever every entry is occupied.
- R4: When both ports need a new entry and exactly one is free, port 0 is accepted and port 1 is rejected.
- R5: A miss to a line held by a pending, non-cancelled entry is accepted into that entry, even when the buffer is full, as long as the entry holds fewer than SLOTS tags. `req_slot` reports that entry. Otherwise the miss is rejected and counted. If both ports name the same line in one cycle, port 1 joins the entry used by port 0.
- R6: A fill with `fill_ready`=1 frees its entry at the next clock edge. For a non-cancelled entry, it produces one `fwd_valid` beat per waiting tag on consecutive cycles, starting one cycle after the fill, in join order, each carrying `fill_data`. `fill_ready` is 0 while more than one beat remains.
- R7: A flush marks every occupied entry cancelled. A cancelled entry is never joined by a later miss, and its fill produces no `fwd_valid` beat.
- R8: A cancelled entry stays occupied until its fill arrives. It still counts toward `buf_full` and still causes rejections.
- R9: A request presented in a flush cycle is neither accepted nor rejected, is not counted and takes no entry. A port with no request gives neither answer.
- R10: A flush ends any forwarding in progress, so `fwd_valid` is 0 in the following cycle. A fill that arrives in a flush cycle is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 2 | Miss request present, one bit per load port |
| req_line | input | 2×LINE_W | Line address per port |
| req_uop | input | 2×UOP_W | Micro-op tag per port |
| flush | input | 1 | Pipeline flush |
| req_accept | output | 2 | Request allocated or joined, per port |
| req_reject | output | 2 | Request refused, per port |
| req_slot | output | 2×IDX_W | Entry index given to each accepted request |
| fill_valid | input | 1 | Line returned from next level |
| fill_slot | input | IDX_W | Entry index of the returned line |
| fill_data | input | DATA_W | Returned data beat |
| fill_ready | output | 1 | A fill can be taken this cycle |
| fwd_valid | output | 1 | Beat forwarded to the pipeline |
| fwd_uop | output | UOP_W | Tag of the load receiving the beat |
| fwd_data | output | DATA_W | Forwarded data |
| buf_full | output | 1 | Every entry occupied |
| full_events | output | CNT_W | Running count of rejected requests |

## Verification
The bench builds the block with 4 entries and 3 tags per entry, instead of the default 10 entries and 2 tags. With this setting a full buffer, the one-free-entry split between the ports, and a rejection because an entry's tag slots are exhausted all occur within a few request cycles. The three-tag entry also shows that forwarding keeps the join order over more than two beats. A full buffer of cancelled entries then shows that requests made after a flush are still refused until each line returns.

// File: rtl/mfb_pkg.sv
// Shared types for the miss fill buffer.
// Assumes: nothing beyond the standard language.
package mfb_pkg;

    // Outcome of one port's request in the current cycle.
    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_ALLOC  = 2'd1,
        RES_MERGE  = 2'd2,
        RES_REJECT = 2'd3
    } req_res_e;

endpackage

// File: rtl/mfb_free_pick.sv
// Finds the lowest and the second-lowest set bit of a free-entry vector.
// Assumes: N >= 2; outputs are purely combinational.
module mfb_free_pick #(
    parameter int N     = 10,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     free_vec,
    output logic             first_ok,
    output logic [IDX_W-1:0] first_idx,
    output logic             second_ok,
    output logic [IDX_W-1:0] second_idx
);

    // Ascending priority scan for the two lowest free entries.
    always_comb begin
        first_ok   = 1'b0;
        second_ok  = 1'b0;
        first_idx  = '0;
        second_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (free_vec[i]) begin
                if (!first_ok) begin
                    first_ok  = 1'b1;
                    first_idx = IDX_W'(i);
                end else if (!second_ok) begin
                    second_ok  = 1'b1;
                    second_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/mfb_drain.sv
// Forward sequencer: takes the tag list of one filled entry and sends one
// beat per tag on consecutive cycles. A kill drops the remaining beats.
// Assumes: load is raised only when ready is high.
module mfb_drain #(
    parameter int SLOTS  = 2,
    parameter int UOP_W  = 7,
    parameter int DATA_W = 64,
    parameter int SW     = 2,
    parameter int SIW    = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [SLOTS-1:0][UOP_W-1:0]  load_uops,
    input  logic [SW-1:0]                load_cnt,
    input  logic [DATA_W-1:0]            load_data,
    input  logic                         kill,
    output logic                         ready,
    output logic                         fwd_valid,
    output logic [UOP_W-1:0]             fwd_uop,
    output logic [DATA_W-1:0]            fwd_data
);

    logic [SLOTS-1:0][UOP_W-1:0] uops_q;
    logic [DATA_W-1:0]           data_q;
    logic [SW-1:0]               left_q;
    logic [SIW-1:0]              pos_q;

    // Beat state: load a new list, step through it, or drop it on kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            pos_q  <= '0;
            data_q <= '0;
            uops_q <= '0;
        end else if (kill) begin
            left_q <= '0;
        end else if (load) begin
            uops_q <= load_uops;
            data_q <= load_data;
            left_q <= load_cnt;
            pos_q  <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - SW'(1);
            pos_q  <= pos_q + SIW'(1);
        end
    end

    // A new list may start while the last beat of the old one goes out.
    assign ready     = (left_q <= SW'(1));
    assign fwd_valid = (left_q != '0);
    assign fwd_uop   = uops_q[pos_q];
    assign fwd_data  = data_q;

endmodule

// File: rtl/miss_fill_buffer.sv
// Miss fill buffer: tracks outstanding line misses from two load ports,
// joins repeat misses to a pending line, forwards returned data per tag,
// and on flush only marks entries cancelled; entries free on fill.
// Assumes: fill_slot names an occupied entry and fill_valid is raised
// only when fill_ready is high.
module miss_fill_buffer
    import mfb_pkg::*;
#(
    parameter int NUM_ENTRIES = 10,
    parameter int SLOTS       = 2,
    parameter int LINE_W      = 26,
    parameter int UOP_W       = 7,
    parameter int DATA_W      = 64,
    parameter int CNT_W       = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   req_valid,
    input  logic [1:0][LINE_W-1:0]       req_line,
    input  logic [1:0][UOP_W-1:0]        req_uop,
    input  logic                         flush,
    output logic [1:0]                   req_accept,
    output logic [1:0]                   req_reject,
    output logic [1:0][IDX_W-1:0]        req_slot,
    input  logic                         fill_valid,
    input  logic [IDX_W-1:0]             fill_slot,
    input  logic [DATA_W-1:0]            fill_data,
    output logic                         fill_ready,
    output logic                         fwd_valid,
    output logic [UOP_W-1:0]             fwd_uop,
    output logic [DATA_W-1:0]            fwd_data,
    output logic                         buf_full,
    output logic [CNT_W-1:0]             full_events
);

    localparam int SW  = $clog2(SLOTS + 1);
    localparam int SIW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [NUM_ENTRIES-1:0]                   ent_valid;
    logic [NUM_ENTRIES-1:0]                   ent_canc;
    logic [NUM_ENTRIES-1:0][LINE_W-1:0]       ent_line;
    logic [NUM_ENTRIES-1:0][SW-1:0]           ent_cnt;
    logic [NUM_ENTRIES-1:0][SLOTS-1:0][UOP_W-1:0] ent_uops;

    logic [NUM_ENTRIES-1:0] leaving, hit0, hit1;
    logic                   f0_ok, f1_ok;
    logic [IDX_W-1:0]       f0_idx, f1_idx;
    logic                   fill_take, drain_load;

    req_res_e         res0, res1;
    logic [IDX_W-1:0] tgt0, tgt1, h0_idx, h1_idx;
    logic             h0_any, h1_any, same_line;
    logic [SW-1:0]    n0;
    logic [SIW-1:0]   pos0, pos1;

    assign fill_take = fill_valid & fill_ready;

    // Per-entry line compare; an entry being filled this cycle is not joinable.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign leaving[g] = fill_take && (fill_slot == IDX_W'(g));
        assign hit0[g] = ent_valid[g] & ~ent_canc[g] & ~leaving[g] &
                         (ent_line[g] == req_line[0]);
        assign hit1[g] = ent_valid[g] & ~ent_canc[g] & ~leaving[g] &
                         (ent_line[g] == req_line[1]);
    end

    mfb_free_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .free_vec   (~ent_valid),
        .first_ok   (f0_ok),
        .first_idx  (f0_idx),
        .second_ok  (f1_ok),
        .second_idx (f1_idx)
    );

    // Encode the (at most one) matching entry for each port.
    always_comb begin
        h0_any = 1'b0;
        h1_any = 1'b0;
        h0_idx = '0;
        h1_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit0[i] && !h0_any) begin h0_any = 1'b1; h0_idx = IDX_W'(i); end
            if (hit1[i] && !h1_any) begin h1_any = 1'b1; h1_idx = IDX_W'(i); end
        end
    end

    // Request decision: port 0 first, port 1 sees what port 0 took.
    always_comb begin
        res0 = RES_NONE;
        tgt0 = '0;
        pos0 = '0;
        if (req_valid[0] && !flush) begin
            if (h0_any) begin
                res0 = (ent_cnt[h0_idx] < SW'(SLOTS)) ? RES_MERGE : RES_REJECT;
                tgt0 = h0_idx;
                pos0 = SIW'(ent_cnt[h0_idx]);
            end else if (f0_ok) begin
                res0 = RES_ALLOC;
                tgt0 = f0_idx;
            end else begin
                res0 = RES_REJECT;
            end
        end
        n0 = (res0 == RES_MERGE) ? ent_cnt[tgt0] + SW'(1) : SW'(1);
        same_line = (res0 == RES_ALLOC || res0 == RES_MERGE) &&
                    (req_line[1] == req_line[0]);
        res1 = RES_NONE;
        tgt1 = '0;
        pos1 = '0;
        if (req_valid[1] && !flush) begin
            if (same_line) begin
                res1 = (n0 < SW'(SLOTS)) ? RES_MERGE : RES_REJECT;
                tgt1 = tgt0;
                pos1 = SIW'(n0);
            end else if (h1_any) begin
                res1 = (ent_cnt[h1_idx] < SW'(SLOTS)) ? RES_MERGE : RES_REJECT;
                tgt1 = h1_idx;
                pos1 = SIW'(ent_cnt[h1_idx]);
            end else if (res0 == RES_ALLOC) begin
                res1 = f1_ok ? RES_ALLOC : RES_REJECT;
                tgt1 = f1_idx;
            end else begin
                res1 = f0_ok ? RES_ALLOC : RES_REJECT;
                tgt1 = f0_idx;
            end
        end
    end

    assign req_accept = {(res1 == RES_ALLOC) || (res1 == RES_MERGE),
                         (res0 == RES_ALLOC) || (res0 == RES_MERGE)};
    assign req_reject = {res1 == RES_REJECT, res0 == RES_REJECT};
    assign req_slot   = {tgt1, tgt0};
    assign buf_full   = &ent_valid;

    // Entry state: free on fill, cancel on flush, allocate or join on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_canc  <= '0;
            ent_line  <= '0;
            ent_cnt   <= '0;
            ent_uops  <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (leaving[i]) begin
                    ent_valid[i] <= 1'b0;
                    ent_canc[i]  <= 1'b0;
                    ent_cnt[i]   <= '0;
                end else begin
                    if (flush && ent_valid[i]) ent_canc[i] <= 1'b1;
                    if (res0 == RES_ALLOC && tgt0 == IDX_W'(i)) begin
                        ent_valid[i]   <= 1'b1;
                        ent_canc[i]    <= 1'b0;
                        ent_line[i]    <= req_line[0];
                        ent_uops[i][0] <= req_uop[0];
                        ent_cnt[i]     <= (res1 == RES_MERGE && tgt1 == IDX_W'(i))
                                          ? SW'(2) : SW'(1);
                    end else if (res1 == RES_ALLOC && tgt1 == IDX_W'(i)) begin
                        ent_valid[i]   <= 1'b1;
                        ent_canc[i]    <= 1'b0;
                        ent_line[i]    <= req_line[1];
                        ent_uops[i][0] <= req_uop[1];
                        ent_cnt[i]     <= SW'(1);
                    end else begin
                        ent_cnt[i] <= ent_cnt[i]
                            + SW'(res0 == RES_MERGE && tgt0 == IDX_W'(i))
                            + SW'(res1 == RES_MERGE && tgt1 == IDX_W'(i));
                    end
                    if (res0 == RES_MERGE && tgt0 == IDX_W'(i))
                        ent_uops[i][pos0] <= req_uop[0];
                    if (res1 == RES_MERGE && tgt1 == IDX_W'(i))
                        ent_uops[i][pos1] <= req_uop[1];
                end
            end
        end
    end

    // Rejection counter: one step per refused port per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) full_events <= '0;
        else full_events <= full_events + CNT_W'(req_reject[0]) + CNT_W'(req_reject[1]);
    end

    assign drain_load = fill_take && ent_valid[fill_slot] && !ent_canc[fill_slot] && !flush;

    mfb_drain #(
        .SLOTS(SLOTS), .UOP_W(UOP_W), .DATA_W(DATA_W), .SW(SW), .SIW(SIW)
    ) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (drain_load),
        .load_uops (ent_uops[fill_slot]),
        .load_cnt  (ent_cnt[fill_slot]),
        .load_data (fill_data),
        .kill      (flush),
        .ready     (fill_ready),
        .fwd_valid (fwd_valid),
        .fwd_uop   (fwd_uop),
        .fwd_data  (fwd_data)
    );

endmodule

// File: rtl/mfb_chk.sv
// Protocol checker for the miss fill buffer, attached by bind.
// Assumes: sees only the top-level ports.
module mfb_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       req_valid,
    input logic             flush,
    input logic [1:0]       req_accept,
    input logic [1:0]       req_reject,
    input logic             fill_valid,
    input logic             fill_ready,
    input logic             fwd_valid,
    input logic [CNT_W-1:0] full_events
);

    // R9
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (req_accept == 2'b00 && req_reject == 2'b00));

    // R9
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~req_valid) & (req_accept | req_reject)) == 2'b00);

    // R3
    event_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> full_events == $past(full_events) + CNT_W'($countones($past(req_reject))));

    // R6
    fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ($past(fwd_valid) || $past(fill_valid && fill_ready)));

    // R6
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |-> fill_ready);

    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fwd_valid);

endmodule

bind miss_fill_buffer mfb_chk #(.CNT_W(CNT_W)) i_mfb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .flush       (flush),
    .req_accept  (req_accept),
    .req_reject  (req_reject),
    .fill_valid  (fill_valid),
    .fill_ready  (fill_ready),
    .fwd_valid   (fwd_valid),
    .full_events (full_events)
);

// File: tb/test_miss_fill_buffer.sv
// Self-checking bench: a request table walked by one loop, then directed
// tests for fill forwarding, flush cancel and the corners around them.
module test_miss_fill_buffer;

    localparam int N  = 4;
    localparam int SL = 3;
    localparam int LW = 8;
    localparam int UW = 6;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int IW = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            req_valid = '0;
    logic [1:0][LW-1:0]    req_line = '0;
    logic [1:0][UW-1:0]    req_uop = '0;
    logic                  flush = 1'b0;
    logic [1:0]            req_accept, req_reject;
    logic [1:0][IW-1:0]    req_slot;
    logic                  fill_valid = 1'b0;
    logic [IW-1:0]         fill_slot = '0;
    logic [DW-1:0]         fill_data = '0;
    logic                  fill_ready, fwd_valid, buf_full;
    logic [UW-1:0]         fwd_uop;
    logic [DW-1:0]         fwd_data;
    logic [CW-1:0]         full_events;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    miss_fill_buffer #(
        .NUM_ENTRIES(N), .SLOTS(SL), .LINE_W(LW), .UOP_W(UW), .DATA_W(DW), .CNT_W(CW)
    ) i_miss_fill_buffer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_uop(req_uop), .flush(flush), .req_accept(req_accept),
        .req_reject(req_reject), .req_slot(req_slot), .fill_valid(fill_valid),
        .fill_slot(fill_slot), .fill_data(fill_data), .fill_ready(fill_ready),
        .fwd_valid(fwd_valid), .fwd_uop(fwd_uop), .fwd_data(fwd_data),
        .buf_full(buf_full), .full_events(full_events)
    );

    typedef struct packed {
        logic [1:0]    v;
        logic [LW-1:0] l0, l1;
        logic [UW-1:0] u0, u1;
        logic [1:0]    acc, rej;
        logic [IW-1:0] s0, s1;
        logic [CW-1:0] ev;
    } vec_t;

    // Request table: each row is one cycle; ev is the counter after the edge.
    localparam vec_t VECS [6] = '{
        '{2'b11, 8'h10, 8'h20, 6'd1, 6'd2, 2'b11, 2'b00, 2'd0, 2'd1, 8'd0}, // R2
        '{2'b11, 8'h10, 8'h30, 6'd3, 6'd4, 2'b11, 2'b00, 2'd0, 2'd2, 8'd0}, // R5 join + R2
        '{2'b11, 8'h40, 8'h50, 6'd5, 6'd6, 2'b01, 2'b10, 2'd3, 2'd0, 8'd1}, // R4
        '{2'b11, 8'h10, 8'h10, 6'd7, 6'd8, 2'b01, 2'b10, 2'd0, 2'd0, 8'd2}, // R5 slot limit
        '{2'b11, 8'h60, 8'h70, 6'd0, 6'd0, 2'b00, 2'b11, 2'd0, 2'd0, 8'd4}, // R3
        '{2'b01, 8'h20, 8'h00, 6'd9, 6'd0, 2'b01, 2'b00, 2'd1, 2'd0, 8'd4}  // R5 join while full
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid  = '0;
        flush      = 1'b0;
        fill_valid = 1'b0;
    endtask

    task automatic req0(input logic [LW-1:0] line, input logic [UW-1:0] uop);
        req_valid   = 2'b01;
        req_line[0] = line;
        req_uop[0]  = uop;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(buf_full == 1'b0, "R1 buf_full", buf_full, 0);
        check(fwd_valid == 1'b0, "R1 fwd_valid", fwd_valid, 0);
        check(full_events == '0, "R1 full_events", full_events, 0);
        check(fill_ready == 1'b1, "R1 fill_ready", fill_ready, 1);

        // Table walk: answers in the request cycle, counter after the edge.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            req_valid = VECS[k].v;
            req_line  = {VECS[k].l1, VECS[k].l0};
            req_uop   = {VECS[k].u1, VECS[k].u0};
            #1;
            check(req_accept == VECS[k].acc, "R2/R3/R4/R5 table accept", req_accept, VECS[k].acc);
            check(req_reject == VECS[k].rej, "R2/R3/R4/R5 table reject", req_reject, VECS[k].rej);
            if (VECS[k].acc[0])
                check(req_slot[0] == VECS[k].s0, "R2/R5 table slot0", req_slot[0], VECS[k].s0);
            if (VECS[k].acc[1])
                check(req_slot[1] == VECS[k].s1, "R2/R5 table slot1", req_slot[1], VECS[k].s1);
            @(posedge clk); #1;
            check(full_events == VECS[k].ev, "R3 table full_events", full_events, VECS[k].ev);
        end
        check(buf_full == 1'b1, "R3 buf_full", buf_full, 1);

        // R6: fill entry 0 (tags 1,3,7) forwards three beats in join order.
        @(negedge clk);
        idle();
        #1;
        check(fill_ready == 1'b1, "R6 ready before fill", fill_ready, 1);
        fill_valid = 1'b1; fill_slot = 2'd0; fill_data = 16'hA0A0;
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check(fwd_valid && fwd_uop == 6'd1, "R6 beat1 uop", fwd_uop, 1);
        check(fwd_data == 16'hA0A0, "R6 beat1 data", fwd_data, 16'hA0A0);
        check(fill_ready == 1'b0, "R6 ready low", fill_ready, 0);
        check(buf_full == 1'b0, "R6 entry freed", buf_full, 0);
        @(negedge clk); #1;
        check(fwd_valid && fwd_uop == 6'd3, "R6 beat2 uop", fwd_uop, 3);
        @(negedge clk); #1;
        check(fwd_valid && fwd_uop == 6'd7, "R6 beat3 uop", fwd_uop, 7);
        check(fill_ready == 1'b1, "R6 ready on last beat", fill_ready, 1);
        @(negedge clk); #1;
        check(fwd_valid == 1'b0, "R6 sequence ends", fwd_valid, 0);

        // R2: the freed entry 0 is the lowest free one.
        req0(8'h80, 6'd10);
        #1;
        check(req_accept[0] && req_slot[0] == 2'd0, "R2 reuse lowest", req_slot[0], 0);

        // R9: request together with flush is dropped.
        @(negedge clk);
        idle();
        req0(8'h90, 6'd11);
        flush = 1'b1;
        #1;
        check(req_accept == 2'b00 && req_reject == 2'b00, "R9 flush request",
              {req_accept, req_reject}, 0);
        @(posedge clk); #1;
        check(full_events == 8'd4, "R9 not counted", full_events, 4);

        // R7/R8: line 0x20 is cancelled, so no join; full buffer refuses it.
        @(negedge clk);
        idle();
        req0(8'h20, 6'd12);
        #1;
        check(req_reject[0] == 1'b1, "R7 no join to cancelled", req_reject, 1);
        @(posedge clk); #1;
        check(full_events == 8'd5, "R8 counted while cancelled", full_events, 5);
        check(buf_full == 1'b1, "R8 cancelled still occupied", buf_full, 1);

        // R7: fill of cancelled entry 1 forwards nothing but frees it.
        @(negedge clk);
        idle();
        fill_valid = 1'b1; fill_slot = 2'd1; fill_data = 16'h1111;
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check(fwd_valid == 1'b0, "R7 cancelled fill silent", fwd_valid, 0);
        check(buf_full == 1'b0, "R8 freed by fill", buf_full, 0);
        req0(8'h20, 6'd13);
        #1;
        check(req_accept[0] && req_slot[0] == 2'd1, "R7 fresh entry", req_slot[0], 1);
        @(negedge clk);
        req0(8'h20, 6'd14);
        #1;
        check(req_accept[0] && req_slot[0] == 2'd1, "R5 join fresh entry", req_slot[0], 1);

        // R10: flush during forwarding stops the remaining beats.
        @(negedge clk);
        idle();
        fill_valid = 1'b1; fill_slot = 2'd1; fill_data = 16'h5555;
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check(fwd_valid && fwd_uop == 6'd13, "R6 first beat", fwd_uop, 13);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        #1;
        check(fwd_valid == 1'b0, "R10 flush stops beats", fwd_valid, 0);

        // R10: fill arriving in a flush cycle is not forwarded.
        req0(8'h33, 6'd20);
        #1;
        check(req_accept[0] && req_slot[0] == 2'd1, "R2 alloc after flush", req_slot[0], 1);
        @(negedge clk);
        idle();
        fill_valid = 1'b1; fill_slot = 2'd1; fill_data = 16'h7777;
        flush = 1'b1;
        @(negedge clk);
        idle();
        #1;
        check(fwd_valid == 1'b0, "R10 fill in flush cycle", fwd_valid, 0);
        check(buf_full == 1'b0, "R6 entry freed on flush-cycle fill", buf_full, 0);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule